// File: doc/BRIEF.md
# Paged Frame Memory Raster Scanner

This block turns a monochrome frame memory organised in pages into a serial pixel stream. In the memory, each byte holds eight vertically stacked pixels of one column. A page is a row of `MEM_COLS` bytes (132 by default). Memory line `n` is found in page `n >> 3` at bit `n & 7`.

The visible window is 96 source pixels wide and 16 source lines tall. It starts at column 36 of every page. Its first line comes from a programmable start line, and the line index wraps modulo 64. Each source pixel is magnified by `MAG` in both directions, so by default the output is 384 x 64 pixels. Two display effects act on every pixel at the output: forcing all pixels lit, and inverting the pixel sense.

Scanning is triggered by a redraw flag. A `redraw_req` pulse sets the flag, and the flag stays set while a frame is being produced. The block clears the flag once the frame's final pixel has been accepted. A request that arrives during a scan is held, and it causes one more frame straight after the current one.

The memory read port has one cycle of latency. The pixel stream is valid/ready. A pixel is transferred on a rising edge where `pix_valid` and `pix_ready` are both high. While `pix_valid` is high and `pix_ready` is low, the pixel and its markers hold steady. Back-pressure only pauses the scan; pixels are never dropped or repeated.

Top module: `raster_scanout`

## Requirements
- R1: Each frame delivers exactly 384 x 64 transferred pixels, with exactly 64 of them carrying `pix_eol`.
- R2: For output row `r`, the source line is `L = (r/4 + start_line) mod 64`. Output column `c` reads byte address `132*(L>>3) + 36 + c/4`, and uses bit `L & 7` (bit 0 = LSB) of that byte.
- R3: Every source pixel fills 4 consecutive output pixels in a row, and every source line fills 4 consecutive output rows.
- R4: Read data on `mem_rd_data` is taken on the clock edge after the one at which `mem_rd_en` was sampled high. Each read belongs to exactly one output pixel.
- R5: With `entire_on` = 0 and `inverse` = 0, a source bit of 1 gives `pix_data` = 1, and a source bit of 0 gives 0.
- R6: With `entire_on` = 0 and `inverse` = 1, a source bit of 1 gives `pix_data` = 0, and a source bit of 0 gives 1.
- R7: With `entire_on` = 1, every pixel has `pix_data` = 1, whatever the memory holds and whatever `inverse` is.
- R8: `pix_sof` is high only on the first pixel of a frame. `pix_eol` is high only on the 384th pixel of each output row.
- R9: While `pix_valid` = 1 and `pix_ready` = 0, the next cycle still has `pix_valid` = 1, with `pix_data`, `pix_sof` and `pix_eol` unchanged.
- R10: After reset, and whenever the redraw flag is clear, no reads are made and no pixels are offered. The flag reads 1 from the edge after a `redraw_req` pulse until the last pixel of the frame is accepted.
- R11: A `redraw_req` that arrives during a scan produces one more complete frame straight after the current one.
- R12: `start_line`, `entire_on` and `inverse` are captured when a frame starts. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redraw_req | input | 1 | One-cycle pulse that sets the redraw flag |
| start_line | input | 6 | First memory line shown on output row 0 |
| entire_on | input | 1 | Force every pixel lit |
| inverse | input | 1 | Invert pixel sense |
| redraw_flag | output | 1 | Redraw pending or frame in progress |
| mem_rd_en | output | 1 | Frame memory read strobe |
| mem_rd_addr | output | 11 | Frame memory byte address |
| mem_rd_data | input | 8 | Read byte, valid one cycle after the strobe |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Sink accepts pixel |
| pix_data | output | 1 | Pixel value, 1 = lit |
| pix_sof | output | 1 | First pixel of frame |
| pix_eol | output | 1 | Last pixel of output row |

## Verification
The bench runs five frames against a memory model that returns byte contents computed per address. It compares every accepted pixel with a reference derived from the line, page, bit and column rules.

A start line of 60 forces the line index to wrap past 63. A design that does not wrap would read beyond the last page, or would show the wrong page and bit. One frame stalls the sink on every third cycle. A design that mishandles the one-cycle read latency under stall would then lose bytes or repeat them, and the comparison would misalign. Configuration is changed in the middle of a frame, which exposes any design that samples it live. A request pulsed during a scan must yield a second frame; a design that drops that request leaves expected pixels unmatched. The forcing frame runs with inverse also set, so any priority error between the two effects shows up as dark pixels.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int PAGE_H = 8;
  localparam int BIT_W  = $clog2(PAGE_H);

  typedef struct packed {
    logic             sof;
    logic             eol;
    logic             last;
    logic [BIT_W-1:0] bitsel;
  } px_tok_t;
endpackage

// File: rtl/scan_gen.sv
module scan_gen
  import raster_pkg::*;
#(
  parameter int SRC_W    = 96,
  parameter int SRC_H    = 16,
  parameter int MAG      = 4,
  parameter int MEM_COLS = 132,
  parameter int COL_OFS  = 36,
  parameter int LINES    = 64,
  parameter int ADDR_W   = 11,
  localparam int LINE_W  = $clog2(LINES),
  localparam int XW      = $clog2(SRC_W),
  localparam int YW      = $clog2(SRC_H),
  localparam int MW      = (MAG > 1) ? $clog2(MAG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LINE_W-1:0] start_line_i,
  input  logic              adv_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output px_tok_t           tok_o
);
  logic [MW-1:0]     xsub, ysub;
  logic [XW-1:0]     xsrc;
  logic [YW-1:0]     ysrc;
  logic              running;
  logic              x_sub_end, x_end, y_sub_end, y_end;
  logic [LINE_W-1:0] line_w;
  logic [LINE_W-BIT_W-1:0] page_w;

  assign x_sub_end = (xsub == MW'(MAG - 1));
  assign x_end     = x_sub_end && (xsrc == XW'(SRC_W - 1));
  assign y_sub_end = (ysub == MW'(MAG - 1));
  assign y_end     = y_sub_end && (ysrc == YW'(SRC_H - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xsub <= '0; ysub <= '0; xsrc <= '0; ysrc <= '0;
      running <= 1'b0;
    end else if (start_i) begin
      xsub <= '0; ysub <= '0; xsrc <= '0; ysrc <= '0;
      running <= 1'b1;
    end else if (running && adv_i) begin
      if (!x_sub_end) begin
        xsub <= xsub + 1'b1;
      end else begin
        xsub <= '0;
        if (!x_end) begin
          xsrc <= xsrc + 1'b1;
        end else begin
          xsrc <= '0;
          if (!y_sub_end) begin
            ysub <= ysub + 1'b1;
          end else begin
            ysub <= '0;
            if (y_end) begin
              ysrc    <= '0;
              running <= 1'b0;
            end else begin
              ysrc <= ysrc + 1'b1;
            end
          end
        end
      end
    end
  end

  assign line_w = LINE_W'(ysrc) + start_line_i;
  assign page_w = line_w[LINE_W-1:BIT_W];

  assign valid_o = running;
  assign addr_o  = ADDR_W'(page_w) * ADDR_W'(MEM_COLS) + ADDR_W'(COL_OFS) + ADDR_W'(xsrc);

  always_comb begin
    tok_o.sof    = (xsub == '0) && (xsrc == '0) && (ysub == '0) && (ysrc == '0);
    tok_o.eol    = x_end;
    tok_o.last   = x_end && y_end;
    tok_o.bitsel = line_w[BIT_W-1:0];
  end

  // R2: every address falls within the visible column window of a page
  p_addr_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((int'(addr_o) % MEM_COLS) >= COL_OFS) &&
                ((int'(addr_o) % MEM_COLS) <  COL_OFS + SRC_W));

  // R1: issuing the final pixel ends the generator
  p_stop_after_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && adv_i && tok_o.last && !start_i) |=> !valid_o);
endmodule

// File: rtl/fetch_stage.sv
module fetch_stage
  import raster_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  px_tok_t           tok_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              take_i,
  output logic              valid_o,
  output px_tok_t           tok_o,
  output logic [DATA_W-1:0] byte_o
);
  logic              valid_q;
  logic              fresh_q;
  logic [DATA_W-1:0] hold_q;
  px_tok_t           tok_q;

  // The byte arrives the cycle after the read; keep it if the stage stalls.
  assign byte_o  = fresh_q ? rd_data_i : hold_q;
  assign valid_o = valid_q;
  assign tok_o   = tok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fresh_q <= 1'b0;
      hold_q  <= '0;
      tok_q   <= '0;
    end else begin
      fresh_q <= issue_i;
      hold_q  <= byte_o;
      if (issue_i) begin
        valid_q <= 1'b1;
        tok_q   <= tok_i;
      end else if (take_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  // R4: a new read never overwrites a byte that has not moved on
  p_no_overwrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !take_i) |-> !issue_i);
endmodule

// File: rtl/pixel_out.sv
module pixel_out
  import raster_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  px_tok_t           tok_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              entire_on_i,
  input  logic              inverse_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic              data_o,
  output logic              sof_o,
  output logic              eol_o,
  output logic              last_o
);
  logic src_bit, shade;

  assign src_bit = byte_i[tok_i.bitsel];

  always_comb begin
    if (entire_on_i)    shade = 1'b1;
    else if (inverse_i) shade = ~src_bit;
    else                shade = src_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= 1'b0;
      sof_o   <= 1'b0;
      eol_o   <= 1'b0;
      last_o  <= 1'b0;
    end else if (take_i) begin
      valid_o <= 1'b1;
      data_o  <= shade;
      sof_o   <= tok_i.sof;
      eol_o   <= tok_i.eol;
      last_o  <= tok_i.last;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // R9: a stalled pixel holds steady
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(sof_o) && $stable(eol_o)));

  // R7: forcing lights every pixel
  p_force_lit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && entire_on_i && $stable(entire_on_i)) |-> data_o);

  // R8: frame start and row end never share a pixel
  p_marker_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !(sof_o && eol_o));
endmodule

// File: rtl/raster_scanout.sv
module raster_scanout
  import raster_pkg::*;
#(
  parameter int SRC_W    = 96,
  parameter int SRC_H    = 16,
  parameter int MAG      = 4,
  parameter int MEM_COLS = 132,
  parameter int COL_OFS  = 36,
  parameter int LINES    = 64,
  parameter int DATA_W   = 8,
  localparam int PAGES   = LINES / PAGE_H,
  localparam int ADDR_W  = $clog2(MEM_COLS * PAGES),
  localparam int LINE_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redraw_req,
  input  logic [LINE_W-1:0] start_line,
  input  logic              entire_on,
  input  logic              inverse,
  output logic              redraw_flag,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic              pix_data,
  output logic              pix_sof,
  output logic              pix_eol
);
  logic              busy, again;
  logic [LINE_W-1:0] cfg_line;
  logic              cfg_on, cfg_inv;
  logic              start, frame_done;
  logic              gen_valid, issue, s1_ready, s1_valid, take;
  px_tok_t           gen_tok, s1_tok;
  logic [DATA_W-1:0] s1_byte;
  logic              out_last;

  assign start      = !busy && redraw_flag;
  assign frame_done = pix_valid && pix_ready && out_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      again       <= 1'b0;
      redraw_flag <= 1'b0;
      cfg_line    <= '0;
      cfg_on      <= 1'b0;
      cfg_inv     <= 1'b0;
    end else begin
      if (frame_done) begin
        redraw_flag <= again | redraw_req;
        again       <= 1'b0;
      end else begin
        if (redraw_req)         redraw_flag <= 1'b1;
        if (busy && redraw_req) again       <= 1'b1;
      end
      if (start) begin
        busy     <= 1'b1;
        cfg_line <= start_line;
        cfg_on   <= entire_on;
        cfg_inv  <= inverse;
      end else if (frame_done) begin
        busy <= 1'b0;
      end
    end
  end

  // Pipeline handshake: stage 1 waits for memory, stage 2 is the output register.
  assign take     = s1_valid && (!pix_valid || pix_ready);
  assign s1_ready = !s1_valid || take;
  assign issue    = gen_valid && s1_ready;
  assign mem_rd_en = issue;

  scan_gen #(
    .SRC_W(SRC_W), .SRC_H(SRC_H), .MAG(MAG), .MEM_COLS(MEM_COLS),
    .COL_OFS(COL_OFS), .LINES(LINES), .ADDR_W(ADDR_W)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_line_i(cfg_line),
    .adv_i(s1_ready), .valid_o(gen_valid), .addr_o(mem_rd_addr), .tok_o(gen_tok)
  );

  fetch_stage #(.DATA_W(DATA_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .tok_i(gen_tok),
    .rd_data_i(mem_rd_data), .take_i(take), .valid_o(s1_valid),
    .tok_o(s1_tok), .byte_o(s1_byte)
  );

  pixel_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .take_i(take), .tok_i(s1_tok), .byte_i(s1_byte),
    .entire_on_i(cfg_on), .inverse_i(cfg_inv), .ready_i(pix_ready),
    .valid_o(pix_valid), .data_o(pix_data), .sof_o(pix_sof), .eol_o(pix_eol),
    .last_o(out_last)
  );

  // R10: no memory traffic while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd_en);

  // R10: the flag stays up for the whole frame
  p_flag_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> redraw_flag);

  // R11: a request held during a scan leaves the flag set at frame end
  p_rerun_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && again) |=> (redraw_flag && !busy));
endmodule

// File: tb/raster_scanout_bench.sv
`timescale 1ns/1ps
module raster_scanout_bench;
  localparam int MEMN = 132 * 8;
  localparam int OW = 384;
  localparam int OH = 64;

  typedef struct packed { logic d; logic sof; logic eol; logic last; } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic redraw_req = 1'b0;
  logic [5:0] start_line = '0;
  logic entire_on = 1'b0, inverse = 1'b0;
  logic redraw_flag, mem_rd_en, pix_valid, pix_data, pix_sof, pix_eol;
  logic [10:0] mem_rd_addr;
  logic [7:0] mem_rd_data = '0;
  logic pix_ready = 1'b1;

  logic [7:0] mem [0:MEMN-1];
  exp_t q[$];
  int checks = 0, errors = 0;
  int frames_done = 0, frame_pix = 0, eol_cnt = 0, col = 0, cyc = 0;
  logic prev_d = 1'b0;
  logic stall_mode = 1'b0;
  logic held = 1'b0, hd, hs, he;
  string tag = "R5";

  always #2.5 clk = ~clk;

  raster_scanout u_raster_scanout (
    .clk(clk), .rst_n(rst_n), .redraw_req(redraw_req), .start_line(start_line),
    .entire_on(entire_on), .inverse(inverse), .redraw_flag(redraw_flag),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .pix_sof(pix_sof), .pix_eol(pix_eol)
  );

  initial begin
    for (int i = 0; i < MEMN; i++) mem[i] = 8'((i * 29) ^ (i >> 3) ^ 8'h5A);
  end

  // Memory model, one cycle of read latency
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= (int'(mem_rd_addr) < MEMN) ? mem[mem_rd_addr] : 8'hxx;
  end

  always @(posedge clk) begin
    cyc++;
    #1 pix_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic push_frame(input int sl, input bit inv, input bit on);
    for (int yo = 0; yo < OH; yo++) begin
      for (int xo = 0; xo < OW; xo++) begin
        int ln, addr;
        bit b;
        exp_t e;
        ln   = (yo / 4 + sl) % 64;
        addr = 132 * (ln / 8) + 36 + xo / 4;
        b    = mem[addr][ln % 8];
        e.d    = on ? 1'b1 : (inv ? ~b : b);
        e.sof  = (yo == 0) && (xo == 0);
        e.eol  = (xo == OW - 1);
        e.last = (yo == OH - 1) && (xo == OW - 1);
        q.push_back(e);
      end
    end
  endtask

  task automatic pulse_req();
    @(negedge clk) redraw_req = 1'b1;
    @(negedge clk) redraw_req = 1'b0;
  endtask

  // Monitor and scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) check(pix_valid && pix_data === hd && pix_sof === hs && pix_eol === he,
                      "R9", "stalled pixel changed", int'(pix_data), int'(hd));
      held = pix_valid && !pix_ready;
      hd = pix_data; hs = pix_sof; he = pix_eol;
      if (pix_valid && pix_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R10", "pixel with nothing expected", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(pix_data === e.d, tag, "pixel value", int'(pix_data), int'(e.d));
          check(pix_sof === e.sof && pix_eol === e.eol, "R8", "markers",
                int'({pix_sof, pix_eol}), int'({e.sof, e.eol}));
          if ((col % 4) != 0)
            check(pix_data === prev_d, "R3", "replicated pixel", int'(pix_data), int'(prev_d));
          prev_d = pix_data;
          frame_pix++;
          if (pix_eol) begin eol_cnt++; col = 0; end else col++;
          if (e.last) begin
            check(frame_pix == OW * OH && eol_cnt == OH, "R1", "frame size",
                  frame_pix, OW * OH);
            frame_pix = 0; eol_cnt = 0; col = 0;
            frames_done++;
          end
        end
      end
    end
  end

  task automatic idle_check(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(!pix_valid && !mem_rd_en, "R10", "activity while idle",
            int'({pix_valid, mem_rd_en}), 0);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", frames_done, 5);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pix_valid && !redraw_flag && !mem_rd_en, "R10", "reset state",
          int'({pix_valid, redraw_flag, mem_rd_en}), 0);
    idle_check(20);

    // Frame A: plain polarity, start line 0
    tag = "R4 R5"; start_line = 6'd0; inverse = 0; entire_on = 0;
    push_frame(0, 0, 0);
    pulse_req();
    check(redraw_flag === 1'b1, "R10", "flag after request", int'(redraw_flag), 1);
    wait (frames_done == 1);
    repeat (3) @(negedge clk);
    check(redraw_flag === 1'b0, "R10", "flag cleared after frame", int'(redraw_flag), 0);
    idle_check(20);

    // Frame B: wrap past line 63, inverse, stalls, config changed mid-frame
    tag = "R2 R6 R9 R12"; start_line = 6'd60; inverse = 1; entire_on = 0;
    stall_mode = 1'b1;
    push_frame(60, 1, 0);
    pulse_req();
    repeat (20) @(negedge clk);
    start_line = 6'd3; inverse = 0; entire_on = 1;
    wait (frames_done == 2);
    stall_mode = 1'b0;
    repeat (5) @(negedge clk);

    // Frame C: forcing wins over inverse
    tag = "R7"; start_line = 6'd5; inverse = 1; entire_on = 1;
    push_frame(5, 1, 1);
    pulse_req();
    wait (frames_done == 3);
    repeat (5) @(negedge clk);

    // Frames D and E: request during a scan
    tag = "R11"; start_line = 6'd17; inverse = 0; entire_on = 0;
    push_frame(17, 0, 0);
    push_frame(17, 0, 0);
    pulse_req();
    repeat (1000) @(negedge clk);
    pulse_req();
    wait (frames_done == 4);
    repeat (3) @(negedge clk);
    check(redraw_flag === 1'b1, "R11", "flag held for second frame", int'(redraw_flag), 1);
    wait (frames_done == 5);
    repeat (3) @(negedge clk);
    check(redraw_flag === 1'b0, "R11", "flag clear after second frame", int'(redraw_flag), 0);
    check(q.size() == 0, "R11", "expected pixels left over", q.size(), 0);
    idle_check(10);
    finish_run();
  end
endmodule